// File: doc/BRIEF.md
# Link Power Supervisor

This block watches the power state of the link layer from the physical-layer side of a serial bus. A synchronized copy of the link power status input is timed while it stays low. A short dip is ignored as a glitch. A dip that lasts into a middle window produces a single reset pulse on the PHY/link interface when the status returns. A dip that outlasts the upper limit disables the interface to save power.

While the interface is disabled, a link-on packet strobe from the packet decoder starts a wake-up clock on a shared contender/link-on pin. The link uses this clock to power itself up. The clock keeps running until the synchronized status is high and the link-active register bit is set in the same cycle. When the pin is not driving the clock it is an input. Its level is captured as the bus-manager contender bit, which goes into bit 20 of the self-ID packet.

All thresholds are counts of system clock cycles. The defaults assume a 50 MHz clock: 60 cycles is 1.2 µs, 1250 cycles is 25 µs, and a half period of 4 gives a wake clock of 6.25 MHz.

Top module: `lps_supervisor`

## Requirements
- R1: After reset `intf_en` is 1 and `intf_rst`, `pin_oe` and `pin_drive` are all 0.
- R2: `lps_in` is sampled through two flops. A low period shorter than `SHORT_CYC` cycles gives no `intf_rst` pulse and leaves `intf_en` at 1.
- R3: A low period of at least `SHORT_CYC` cycles that ends before `LONG_CYC` cycles gives exactly one `intf_rst` pulse of `RST_LEN` cycles once the status returns. `intf_en` stays at 1 throughout.
- R4: When `LONG_CYC` consecutive low samples are reached, `intf_en` goes to 0. No `intf_rst` pulse is issued when that episode ends.
- R5: While disabled, `intf_en` returns to 1 on the third rising edge after `lps_in` goes high.
- R6: A `linkon_stb` high on an edge while `intf_en` is 0 sets `pin_oe` to 1. `pin_drive` then runs at 50% duty with a period of 2·`WAKE_HALF` cycles, starting with a low half.
- R7: A `linkon_stb` while `intf_en` is 1 is ignored, and `pin_oe` stays 0.
- R8: Further `linkon_stb` pulses during wake-clock generation do not change the divider phase.
- R9: The wake clock stops only when the synchronized status is high and `link_active` is 1 on the same edge. On the following cycle `pin_oe` and `pin_drive` are 0.
- R10: `contender_bit` follows `contender_in` with a one-cycle delay while `pin_oe` is 0, and holds its value while `pin_oe` is 1.
- R11: `pin_drive` is 0 whenever `pin_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lps_in | input | 1 | Link power status from the link layer, asynchronous |
| linkon_stb | input | 1 | One-cycle strobe: a link-on packet was received |
| link_active | input | 1 | Link-active register bit |
| contender_in | input | 1 | Level read from the shared pin when it is not driven |
| intf_rst | output | 1 | Reset pulse for the PHY/link interface |
| intf_en | output | 1 | PHY/link interface enable |
| pin_drive | output | 1 | Wake-clock value for the shared pin |
| pin_oe | output | 1 | Output enable for the shared pin |
| contender_bit | output | 1 | Bus-manager contender bit for the self-ID packet |

## Verification
The inactivity timer is exercised with three low-pulse lengths: one just under the lower threshold, one inside the reset window and one past the upper limit. These separate "ignored", "reset pulse, still enabled" and "disabled, no pulse". The link-on strobe is applied once while the interface is enabled and again while it is disabled, which separates an ignored strobe from a wake start. During the wake clock a second strobe is sent, and the divider phase is checked cycle by cycle against a phase that was not restarted. Status-high is then applied with the link-active bit clear and afterwards with it set, to show that the clock stops only when both conditions hold together.

// File: rtl/lps_pkg.sv
package lps_pkg;
  typedef enum logic {
    LINK_UP   = 1'b0,
    LINK_DOWN = 1'b1
  } link_state_e;
endpackage

// File: rtl/lps_sync.sv
module lps_sync #(
  parameter int STAGES  = 2,
  parameter bit RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_in,
  output logic d_out
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= {STAGES{RST_VAL}};
    else        chain <= {chain[STAGES-2:0], d_in};
  end

  assign d_out = chain[STAGES-1];
endmodule

// File: rtl/lps_idle_timer.sv
module lps_idle_timer
  import lps_pkg::*;
#(
  parameter int SHORT_CYC = 60,
  parameter int LONG_CYC  = 1250,
  parameter int RST_LEN   = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lps_s,
  output logic intf_en,
  output logic intf_rst
);
  localparam int CW = $clog2(LONG_CYC + 1);
  localparam int RW = $clog2(RST_LEN + 1);

  link_state_e     state;
  logic [CW-1:0]   idle_cnt;
  logic [RW-1:0]   rst_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= LINK_UP;
      idle_cnt <= '0;
      rst_cnt  <= '0;
    end else begin
      if (rst_cnt != '0) rst_cnt <= rst_cnt - 1'b1;
      if (lps_s) begin
        idle_cnt <= '0;
        if (state == LINK_DOWN) begin
          state <= LINK_UP;
        end else if (idle_cnt >= CW'(SHORT_CYC)) begin
          rst_cnt <= RW'(RST_LEN);
        end
      end else if (state == LINK_UP) begin
        idle_cnt <= idle_cnt + 1'b1;
        if (idle_cnt == CW'(LONG_CYC - 1)) state <= LINK_DOWN;
      end
    end
  end

  assign intf_en  = (state == LINK_UP);
  assign intf_rst = (rst_cnt != '0);
endmodule

// File: rtl/wake_clk_gen.sv
module wake_clk_gen #(
  parameter int WAKE_HALF = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic link_down,
  input  logic linkon_stb,
  input  logic lps_s,
  input  logic link_active,
  output logic pin_drive,
  output logic pin_oe
);
  localparam int DW = (WAKE_HALF > 1) ? $clog2(WAKE_HALF) : 1;

  logic          running;
  logic          phase;
  logic [DW-1:0] div_cnt;
  logic          stop_req;

  assign stop_req = lps_s && link_active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      phase   <= 1'b0;
      div_cnt <= '0;
    end else if (running) begin
      if (stop_req) begin
        running <= 1'b0;
        phase   <= 1'b0;
        div_cnt <= '0;
      end else if (div_cnt == DW'(WAKE_HALF - 1)) begin
        div_cnt <= '0;
        phase   <= ~phase;
      end else begin
        div_cnt <= div_cnt + 1'b1;
      end
    end else if (link_down && linkon_stb && !stop_req) begin
      running <= 1'b1;
      phase   <= 1'b0;
      div_cnt <= '0;
    end
  end

  assign pin_oe    = running;
  assign pin_drive = running & phase;
endmodule

// File: rtl/lps_supervisor.sv
module lps_supervisor #(
  parameter int SHORT_CYC = 60,
  parameter int LONG_CYC  = 1250,
  parameter int RST_LEN   = 8,
  parameter int WAKE_HALF = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lps_in,
  input  logic linkon_stb,
  input  logic link_active,
  input  logic contender_in,
  output logic intf_rst,
  output logic intf_en,
  output logic pin_drive,
  output logic pin_oe,
  output logic contender_bit
);
  logic lps_s;

  lps_sync #(.STAGES(2), .RST_VAL(1'b1)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  (lps_in),
    .d_out (lps_s)
  );

  lps_idle_timer #(
    .SHORT_CYC (SHORT_CYC),
    .LONG_CYC  (LONG_CYC),
    .RST_LEN   (RST_LEN)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .lps_s    (lps_s),
    .intf_en  (intf_en),
    .intf_rst (intf_rst)
  );

  wake_clk_gen #(.WAKE_HALF(WAKE_HALF)) u_wake (
    .clk         (clk),
    .rst_n       (rst_n),
    .link_down   (!intf_en),
    .linkon_stb  (linkon_stb),
    .lps_s       (lps_s),
    .link_active (link_active),
    .pin_drive   (pin_drive),
    .pin_oe      (pin_oe)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       contender_bit <= 1'b0;
    else if (!pin_oe) contender_bit <= contender_in;
  end
endmodule

// File: rtl/lps_supervisor_chk.sv
module lps_supervisor_chk (
  input logic clk,
  input logic rst_n,
  input logic lps_s,
  input logic linkon_stb,
  input logic link_active,
  input logic intf_rst,
  input logic intf_en,
  input logic pin_drive,
  input logic pin_oe,
  input logic contender_bit
);
  assert_drive_needs_oe_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_oe |-> !pin_drive);

  assert_rst_only_enabled_R3: assert property (@(posedge clk) disable iff (!rst_n)
    intf_rst |-> intf_en);

  assert_rst_after_return_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(intf_rst) |-> $past(lps_s));

  assert_wake_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pin_oe) |-> $past(!intf_en && linkon_stb));

  assert_wake_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe && lps_s && link_active) |=> !pin_oe);

  assert_wake_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pin_oe) |-> $past(lps_s && link_active));

  assert_contender_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(pin_oe) |-> $stable(contender_bit));

  assert_disable_on_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(intf_en) |-> $past(!lps_s));
endmodule

bind lps_supervisor lps_supervisor_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .lps_s         (lps_s),
  .linkon_stb    (linkon_stb),
  .link_active   (link_active),
  .intf_rst      (intf_rst),
  .intf_en       (intf_en),
  .pin_drive     (pin_drive),
  .pin_oe        (pin_oe),
  .contender_bit (contender_bit)
);

// File: tb/test_lps_supervisor.sv
`timescale 1ns/1ps
module test_lps_supervisor;
  localparam int SHORT = 20;
  localparam int LONG  = 100;
  localparam int RLEN  = 3;
  localparam int HALF  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lps_in = 1'b1;
  logic linkon_stb = 1'b0;
  logic link_active = 1'b0;
  logic contender_in = 1'b0;
  logic intf_rst, intf_en, pin_drive, pin_oe, contender_bit;

  int checks = 0;
  int fails  = 0;
  int rst_cycles = 0;

  always #10 clk = ~clk;

  lps_supervisor #(
    .SHORT_CYC(SHORT), .LONG_CYC(LONG), .RST_LEN(RLEN), .WAKE_HALF(HALF)
  ) i_lps_supervisor (
    .clk(clk), .rst_n(rst_n), .lps_in(lps_in), .linkon_stb(linkon_stb),
    .link_active(link_active), .contender_in(contender_in),
    .intf_rst(intf_rst), .intf_en(intf_en), .pin_drive(pin_drive),
    .pin_oe(pin_oe), .contender_bit(contender_bit)
  );

  always @(negedge clk) if (intf_rst) rst_cycles++;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset_state;
    check(intf_en == 1'b1, "R1 intf_en", intf_en, 1);
    check(intf_rst == 1'b0, "R1 intf_rst", intf_rst, 0);
    check(pin_oe == 1'b0, "R1 pin_oe", pin_oe, 0);
    check(pin_drive == 1'b0, "R1 pin_drive", pin_drive, 0);
  endtask

  task automatic t_glitch;
    rst_cycles = 0;
    lps_in = 1'b0; cyc(SHORT - 5);
    lps_in = 1'b1; cyc(10);
    check(rst_cycles == 0, "R2 no reset pulse", rst_cycles, 0);
    check(intf_en == 1'b1, "R2 still enabled", intf_en, 1);
  endtask

  task automatic t_reset_window;
    rst_cycles = 0;
    lps_in = 1'b0; cyc(SHORT + 10);
    check(intf_en == 1'b1, "R3 enabled while low", intf_en, 1);
    lps_in = 1'b1; cyc(RLEN + 8);
    check(rst_cycles == RLEN, "R3 pulse length", rst_cycles, RLEN);
    check(intf_en == 1'b1, "R3 enabled after", intf_en, 1);
  endtask

  task automatic t_disable;
    rst_cycles = 0;
    lps_in = 1'b0; cyc(LONG);
    check(intf_en == 1'b1, "R4 enabled before limit", intf_en, 1);
    cyc(4);
    check(intf_en == 1'b0, "R4 disabled after limit", intf_en, 0);
    linkon_stb = 1'b1; cyc(1);
    linkon_stb = 1'b0;
  endtask

  task automatic t_ignore_strobe;
    linkon_stb = 1'b1; cyc(1);
    linkon_stb = 1'b0; cyc(5);
    check(pin_oe == 1'b0, "R7 strobe ignored when enabled", pin_oe, 0);
  endtask

  task automatic t_contender_follow;
    contender_in = 1'b1; cyc(1);
    check(contender_bit == 1'b1, "R10 follows input", contender_bit, 1);
  endtask

  task automatic t_wake_clock;
    int exp;
    bit bad_drive;
    bit bad_oe;
    bad_drive = 1'b0;
    bad_oe = 1'b0;
    check(pin_oe == 1'b1, "R6 oe after strobe", pin_oe, 1);
    for (int i = 0; i < 4 * HALF; i++) begin
      exp = (i / HALF) % 2;
      if (pin_drive != exp[0]) bad_drive = 1'b1;
      if (!pin_oe) bad_oe = 1'b1;
      if (i == 2) begin
        linkon_stb = 1'b1;
        contender_in = 1'b0;
      end
      if (i == 3) linkon_stb = 1'b0;
      @(negedge clk);
    end
    check(!bad_oe, "R6 oe held during wake", bad_oe, 0);
    check(!bad_drive, "R8 phase not restarted by repeat strobe", bad_drive, 0);
    check(contender_bit == 1'b1, "R10 held while driving", contender_bit, 1);
  endtask

  task automatic t_wake_stop;
    rst_cycles = 0;
    lps_in = 1'b1; cyc(2);
    check(intf_en == 1'b0, "R5 not yet enabled", intf_en, 0);
    cyc(1);
    check(intf_en == 1'b1, "R5 re-enabled", intf_en, 1);
    cyc(5);
    check(pin_oe == 1'b1, "R9 wake runs without link_active", pin_oe, 1);
    check(rst_cycles == 0, "R4 no pulse after disable episode", rst_cycles, 0);
    link_active = 1'b1; cyc(1);
    check(pin_oe == 1'b0, "R9 oe off", pin_oe, 0);
    check(pin_drive == 1'b0, "R11 drive low when oe off", pin_drive, 0);
    contender_in = 1'b0; cyc(1);
    check(contender_bit == 1'b0, "R10 follows again", contender_bit, 0);
  endtask

  initial begin
    #2_000_000;
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(2);
    t_reset_state();
    t_ignore_strobe();
    t_glitch();
    t_reset_window();
    t_contender_follow();
    t_disable();
    t_wake_clock();
    t_wake_stop();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule